// File: doc/BRIEF.md
# Snooping Scanline Interrupt Counter

This block counts rendered scanlines and raises a CPU interrupt at a programmed line. It has no access to the video timing signals. Everything it knows comes from the stream of addresses the picture processor reads from video memory. The picture processor fetches the same nametable byte several times in a row at the end of each line. The block treats such a repeat as the start of a new line. When the video bus has been quiet for a few CPU cycles, the block concludes that rendering has stopped.

The CPU programs a target line count and an enable bit. It polls or acknowledges through a status register, which reports the interrupt-pending flag and the in-frame flag. When the CPU fetches the interrupt vector, the block treats this as the end of a frame and clears its frame state. The block also exports a fetch-slot counter. This counter advances on every nametable fetch and restarts at each detected line start, so that neighbouring logic can tell which tile column is being fetched.

Top module: `scanline_snoop_irq`

## Requirements
- R1: A line start is recognised on the third consecutive video read of one identical address inside 0x2000..0x2FFF, and again on every further identical read. A read of a different address, or any read outside that window, restarts the repeat count.
- R2: A nametable fetch is a video read inside 0x2000..0x2FFF whose low ten address bits are below 0x3C0. Each nametable fetch raises the fetch-slot counter by one. A line start forces the counter to 0 in the same update.
- R3: A line start that arrives while the block is out of frame and no frame start is armed arms a frame start and clears the line count. It raises no interrupt, and the in-frame flag stays low.
- R4: An armed frame start turns into the in-frame flag at the next nametable fetch.
- R5: Every other line start adds one to the line count. When the new count equals the target register, the pending flag is set. The interrupt output is high exactly while pending and enable are both set.
- R6: Register select 1 is status/control and select 0 is the target. A status read returns pending in bit 7, in-frame in bit 6 and zeros elsewhere, and it clears pending, so the interrupt drops on the next cycle. Reading the target select returns 0.
- R7: Writing status/control loads enable from bit 7. Writing 0 in bit 7 drops the interrupt. Writing 1 while pending is set raises it on the next cycle.
- R8: Every video read reloads an idle counter with 3. Each CPU cycle enable with no video read counts it down, and the step that reaches 0 clears the in-frame flag.
- R9: A CPU vector fetch clears the in-frame flag, the line count, the pending flag, the interrupt and the remembered last address.
- R10: After reset all flags and counters are 0. The fetch-slot counter stops at its maximum value (63 by default) and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vid_rd | input | 1 | One-cycle strobe marking a video memory read |
| vid_addr | input | ADDR_W (14) | Video read address |
| cpu_tick | input | 1 | One-cycle enable per CPU cycle |
| vec_fetch | input | 1 | CPU is reading an interrupt vector byte |
| reg_wr | input | 1 | CPU register write strobe |
| reg_rd | input | 1 | CPU register read strobe |
| reg_sel | input | 1 | 0 = target line, 1 = status/control |
| reg_wdata | input | DATA_W (8) | CPU write data |
| reg_rdata | output | DATA_W (8) | CPU read data, valid in the cycle of reg_rd |
| irq | output | 1 | Interrupt request, active high |
| in_frame | output | 1 | Rendering is believed active |
| slot_cnt | output | SLOT_W (6) | Nametable fetches since the last line start |

## Verification
The bench targets the repeat detector's corner cases. It inserts an out-of-window read and an attribute read between identical nametable reads, and it issues a fourth identical read. A detector that failed to restart its count would declare a false line start and zero the slot counter too early. A detector that fired only once would leave the slot counter at 1. The bench checks the arm-then-promote sequence at frame start, because a design that counted the first line would raise the interrupt one line too early. It probes the idle window at two and three quiet CPU cycles, with a read in between, to catch a window that is one cycle off or that a read fails to reload. The bench also checks that enabling while pending raises the interrupt, that disabling keeps the pending flag, and that a vector fetch clears everything. An interrupt tied only to the pending flag, or a pending flag lost on disable, would fail these checks.

// File: rtl/snoop_pkg.sv
package snoop_pkg;
   localparam logic SEL_TARGET     = 1'b0;
   localparam logic SEL_STATUS     = 1'b1;
   localparam int   STAT_PEND_BIT  = 7;
   localparam int   STAT_FRAME_BIT = 6;
   localparam int   CTRL_EN_BIT    = 7;
   localparam int   NT_WIN_LO      = 'h2000;
   localparam int   NT_WIN_HI      = 'h2FFF;
   localparam int   ATTR_OFFSET    = 'h3C0;
endpackage

// File: rtl/snoop_line_detect.sv
module snoop_line_detect #(
   parameter int ADDR_W    = 14,
   parameter int REP_LIMIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vid_rd,
   input  logic [ADDR_W-1:0] vid_addr,
   input  logic              vec_fetch,
   output logic              nt_fetch,
   output logic              line_start
);
   import snoop_pkg::*;

   localparam int REP_W = $clog2(REP_LIMIT + 1);
   localparam logic [ADDR_W-1:0] WIN_LO = ADDR_W'(NT_WIN_LO);
   localparam logic [ADDR_W-1:0] WIN_HI = ADDR_W'(NT_WIN_HI);
   localparam logic [9:0]        ATTR_LO = 10'(ATTR_OFFSET);
   localparam logic [REP_W-1:0]  REP_TOP = REP_W'(REP_LIMIT);

   logic [ADDR_W-1:0] last_q;
   logic [REP_W-1:0]  rep_q, rep_d;
   logic              in_win, same_addr;

   assign in_win    = (vid_addr >= WIN_LO) && (vid_addr <= WIN_HI);
   assign same_addr = (vid_addr == last_q);
   assign nt_fetch  = vid_rd && in_win && (vid_addr[9:0] < ATTR_LO);

   always_comb begin
      rep_d = rep_q;
      if (vid_rd) begin
         if (in_win && same_addr)
            rep_d = (rep_q == REP_TOP) ? rep_q : rep_q + REP_W'(1);
         else
            rep_d = '0;
      end
   end

   assign line_start = vid_rd && in_win && same_addr && (rep_d == REP_TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         rep_q  <= '0;
      end else begin
         rep_q <= rep_d;
         if (vec_fetch)
            last_q <= '0;
         else if (vid_rd)
            last_q <= vid_addr;
      end
   end
endmodule

// File: rtl/snoop_frame_track.sv
module snoop_frame_track #(
   parameter int IDLE_TICKS = 3,
   parameter int SLOT_W     = 6,
   parameter bit SLOT_SAT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vid_rd,
   input  logic              nt_fetch,
   input  logic              line_start,
   input  logic              cpu_tick,
   input  logic              vec_fetch,
   output logic              in_frame,
   output logic              frame_pend,
   output logic              frame_arm,
   output logic              line_count,
   output logic [SLOT_W-1:0] slot_cnt
);
   localparam int IDLE_W = $clog2(IDLE_TICKS + 1);
   localparam logic [IDLE_W-1:0] IDLE_LOAD = IDLE_W'(IDLE_TICKS);
   localparam logic [SLOT_W-1:0] SLOT_MAX  = {SLOT_W{1'b1}};

   logic              in_frame_q, pend_q;
   logic [IDLE_W-1:0] idle_q, idle_d;
   logic [SLOT_W-1:0] slot_q, slot_inc;
   logic              promote, in_frame_eff, pend_eff, idle_expire;

   assign promote      = nt_fetch && pend_q;
   assign in_frame_eff = in_frame_q || promote;
   assign pend_eff     = pend_q && !promote;
   assign frame_arm    = line_start && !in_frame_eff && !pend_eff;
   assign line_count   = line_start && !frame_arm;
   assign idle_expire  = cpu_tick && !vid_rd && (idle_q == IDLE_W'(1));

   always_comb begin
      idle_d = idle_q;
      if (vid_rd)
         idle_d = IDLE_LOAD;
      else if (cpu_tick && idle_q != '0)
         idle_d = idle_q - IDLE_W'(1);
   end

   generate
      if (SLOT_SAT) begin : g_slot_sat
         assign slot_inc = (slot_q == SLOT_MAX) ? slot_q : slot_q + SLOT_W'(1);
      end else begin : g_slot_wrap
         assign slot_inc = slot_q + SLOT_W'(1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
         pend_q     <= 1'b0;
         idle_q     <= '0;
         slot_q     <= '0;
      end else begin
         idle_q     <= idle_d;
         pend_q     <= frame_arm ? 1'b1 : pend_eff;
         in_frame_q <= (vec_fetch || idle_expire) ? 1'b0 : in_frame_eff;
         if (line_start)
            slot_q <= '0;
         else if (nt_fetch)
            slot_q <= slot_inc;
      end
   end

   assign in_frame   = in_frame_q;
   assign frame_pend = pend_q;
   assign slot_cnt   = slot_q;
endmodule

// File: rtl/snoop_irq_ctrl.sv
module snoop_irq_ctrl #(
   parameter int CNT_W  = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_clear,
   input  logic              scan_inc,
   input  logic              vec_fetch,
   input  logic              in_frame,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              scan_hit,
   output logic              irq
);
   import snoop_pkg::*;

   logic [CNT_W-1:0] scan_q, target_q, scan_next;
   logic             en_q, pend_q, status_rd, ctrl_wr, target_wr;

   assign scan_next = scan_q + CNT_W'(1);
   assign scan_hit  = scan_inc && (scan_next == target_q);
   assign status_rd = reg_rd && (reg_sel == SEL_STATUS);
   assign ctrl_wr   = reg_wr && (reg_sel == SEL_STATUS);
   assign target_wr = reg_wr && (reg_sel == SEL_TARGET);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_q   <= '0;
         target_q <= '0;
         en_q     <= 1'b0;
         pend_q   <= 1'b0;
      end else begin
         if (scan_clear)
            scan_q <= '0;
         else if (scan_inc)
            scan_q <= scan_next;

         if (target_wr)
            target_q <= reg_wdata[CNT_W-1:0];
         if (ctrl_wr)
            en_q <= reg_wdata[CTRL_EN_BIT];

         if (vec_fetch)
            pend_q <= 1'b0;
         else if (scan_hit)
            pend_q <= 1'b1;
         else if (status_rd)
            pend_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (status_rd) begin
         reg_rdata[STAT_PEND_BIT]  = pend_q;
         reg_rdata[STAT_FRAME_BIT] = in_frame;
      end
   end

   assign irq = pend_q && en_q;
endmodule

// File: rtl/scanline_snoop_irq.sv
module scanline_snoop_irq #(
   parameter int ADDR_W     = 14,
   parameter int DATA_W     = 8,
   parameter int CNT_W      = 8,
   parameter int SLOT_W     = 6,
   parameter int REP_LIMIT  = 2,
   parameter int IDLE_TICKS = 3,
   parameter bit SLOT_SAT   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vid_rd,
   input  logic [ADDR_W-1:0] vid_addr,
   input  logic              cpu_tick,
   input  logic              vec_fetch,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              in_frame,
   output logic [SLOT_W-1:0] slot_cnt
);
   generate
      if (ADDR_W < 14) begin : g_chk_addr
         $error("ADDR_W must cover the nametable window");
      end
      if (DATA_W < 8) begin : g_chk_data
         $error("DATA_W must hold the status bits");
      end
      if (CNT_W > DATA_W || CNT_W < 1) begin : g_chk_cnt
         $error("CNT_W must be 1..DATA_W");
      end
      if (REP_LIMIT < 1 || IDLE_TICKS < 1 || SLOT_W < 1) begin : g_chk_misc
         $error("REP_LIMIT, IDLE_TICKS and SLOT_W must be positive");
      end
   endgenerate

   logic nt_fetch, line_start, frame_pend, frame_arm, line_count, scan_hit;

   snoop_line_detect #(.ADDR_W(ADDR_W), .REP_LIMIT(REP_LIMIT)) u_detect (
      .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .vid_addr(vid_addr),
      .vec_fetch(vec_fetch), .nt_fetch(nt_fetch), .line_start(line_start)
   );

   snoop_frame_track #(.IDLE_TICKS(IDLE_TICKS), .SLOT_W(SLOT_W), .SLOT_SAT(SLOT_SAT)) u_frame (
      .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .nt_fetch(nt_fetch),
      .line_start(line_start), .cpu_tick(cpu_tick), .vec_fetch(vec_fetch),
      .in_frame(in_frame), .frame_pend(frame_pend), .frame_arm(frame_arm),
      .line_count(line_count), .slot_cnt(slot_cnt)
   );

   snoop_irq_ctrl #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_irq (
      .clk(clk), .rst_n(rst_n), .scan_clear(frame_arm | vec_fetch),
      .scan_inc(line_count), .vec_fetch(vec_fetch), .in_frame(in_frame),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .scan_hit(scan_hit), .irq(irq)
   );
endmodule

// File: rtl/scanline_snoop_irq_chk.sv
module scanline_snoop_irq_chk #(
   parameter int DATA_W   = 8,
   parameter int SLOT_W   = 6,
   parameter bit SLOT_SAT = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vec_fetch,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic              reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic              irq,
   input logic              in_frame,
   input logic [SLOT_W-1:0] slot_cnt,
   input logic              line_start,
   input logic              frame_pend,
   input logic              scan_hit
);
   localparam logic [SLOT_W-1:0] SLOT_TOP = {SLOT_W{1'b1}};

   AST_SLOT_LINE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> (slot_cnt == '0)); // R2
   AST_FRAME_FROM_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_frame) |-> $past(frame_pend)); // R4
   AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(scan_hit) || $past(reg_wr && reg_sel && reg_wdata[7]))); // R5
   AST_STATUS_RD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_sel && !scan_hit) |=> !irq); // R6
   AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel && !reg_wdata[7]) |=> !irq); // R7
   AST_VECTOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      vec_fetch |=> (!in_frame && !irq)); // R9

   generate
      if (SLOT_SAT) begin : g_sat_chk
         AST_SLOT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_cnt == SLOT_TOP && !line_start) |=> (slot_cnt == SLOT_TOP)); // R10
      end
   endgenerate
endmodule

bind scanline_snoop_irq scanline_snoop_irq_chk #(
   .DATA_W(DATA_W), .SLOT_W(SLOT_W), .SLOT_SAT(SLOT_SAT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .vec_fetch(vec_fetch), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .irq(irq),
   .in_frame(in_frame), .slot_cnt(slot_cnt), .line_start(line_start),
   .frame_pend(frame_pend), .scan_hit(scan_hit)
);

// File: tb/scanline_snoop_irq_tb.sv
module scanline_snoop_irq_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vid_rd = 1'b0;
   logic [13:0] vid_addr = '0;
   logic        cpu_tick = 1'b0;
   logic        vec_fetch = 1'b0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic        reg_sel = 1'b0;
   logic [7:0]  reg_wdata = '0;
   logic [7:0]  reg_rdata;
   logic        irq, in_frame;
   logic [5:0]  slot_cnt;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   scanline_snoop_irq u_dut (
      .clk(clk), .rst_n(rst_n), .vid_rd(vid_rd), .vid_addr(vid_addr),
      .cpu_tick(cpu_tick), .vec_fetch(vec_fetch), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq), .in_frame(in_frame), .slot_cnt(slot_cnt)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic vread(input logic [13:0] a);
      @(negedge clk); vid_rd = 1'b1; vid_addr = a;
      @(negedge clk); vid_rd = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); cpu_tick = 1'b1;
      @(negedge clk); cpu_tick = 1'b0;
   endtask

   task automatic vector();
      @(negedge clk); vec_fetch = 1'b1;
      @(negedge clk); vec_fetch = 1'b0;
   endtask

   task automatic wr(input logic sel, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic sel, output logic [7:0] v);
      @(negedge clk); reg_rd = 1'b1; reg_sel = sel;
      #1 v = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   task automatic start_frame();
      vread(14'h2000); vread(14'h2000); vread(14'h2000);
      vread(14'h2001);
   endtask

   task automatic do_line(input logic [13:0] a);
      vread(a); vread(a); vread(a);
      vread(a + 14'd1);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      chk("R10 in_frame after reset", in_frame, 0);
      chk("R10 irq after reset", irq, 0);
      chk("R10 slot after reset", slot_cnt, 0);
      rd(1'b1, v);
      chk("R10 status after reset", v, 8'h00);
   endtask

   task automatic t_repeat();
      do_reset();
      vread(14'h2010); vread(14'h2010);
      chk("R2 two nametable fetches", slot_cnt, 2);
      vread(14'h3000);
      chk("R2 out-of-window read not counted", slot_cnt, 2);
      vread(14'h2010);
      chk("R1 out-of-window read restarts repeat", slot_cnt, 3);
      vread(14'h23C0);
      chk("R2 attribute read not counted", slot_cnt, 3);
      vread(14'h2010); vread(14'h2010);
      chk("R1 two repeats are not a line start", slot_cnt, 5);
      vread(14'h2010);
      chk("R1 third identical read clears slot", slot_cnt, 0);
      chk("R3 arming leaves in_frame low", in_frame, 0);
      chk("R3 arming raises no irq", irq, 0);
      vread(14'h2011);
      chk("R4 next fetch enters frame", in_frame, 1);
      chk("R2 slot counts after line start", slot_cnt, 1);
   endtask

   task automatic t_fourth();
      do_reset();
      start_frame();
      vread(14'h2100); vread(14'h2100); vread(14'h2100);
      vread(14'h2100);
      chk("R1 fourth identical read is a line start", slot_cnt, 0);
      vread(14'h2101);
      chk("R2 slot after fourth read", slot_cnt, 1);
   endtask

   task automatic t_irq_count();
      logic [7:0] v;
      do_reset();
      wr(1'b0, 8'd2);
      wr(1'b1, 8'h80);
      start_frame();
      do_line(14'h2040);
      chk("R5 no irq on line 1 with target 2", irq, 0);
      do_line(14'h2080);
      chk("R5 irq on line 2 with target 2", irq, 1);
      rd(1'b1, v);
      chk("R6 status shows pending and in-frame", v, 8'hC0);
      chk("R6 status read releases irq", irq, 0);
      rd(1'b1, v);
      chk("R6 pending cleared by read", v, 8'h40);
      rd(1'b0, v);
      chk("R6 target select reads zero", v, 8'h00);
   endtask

   task automatic t_enable();
      logic [7:0] v;
      do_reset();
      wr(1'b0, 8'd1);
      wr(1'b1, 8'h00);
      start_frame();
      do_line(14'h2050);
      chk("R5 pending without enable gives no irq", irq, 0);
      wr(1'b1, 8'h80);
      chk("R7 enabling while pending raises irq", irq, 1);
      wr(1'b1, 8'h00);
      chk("R7 disabling releases irq", irq, 0);
      rd(1'b1, v);
      chk("R7 disable keeps pending", v, 8'hC0);
   endtask

   task automatic t_idle();
      do_reset();
      start_frame();
      chk("R4 in frame before idle", in_frame, 1);
      tick(); tick();
      chk("R8 two quiet ticks keep frame", in_frame, 1);
      vread(14'h2200);
      tick(); tick();
      chk("R8 read reloads idle window", in_frame, 1);
      tick();
      chk("R8 third quiet tick ends frame", in_frame, 0);
   endtask

   task automatic t_vector();
      logic [7:0] v;
      do_reset();
      wr(1'b0, 8'd1);
      wr(1'b1, 8'h80);
      start_frame();
      do_line(14'h2060);
      chk("R5 irq at target 1", irq, 1);
      vector();
      chk("R9 vector clears irq", irq, 0);
      chk("R9 vector clears in_frame", in_frame, 0);
      rd(1'b1, v);
      chk("R9 vector clears pending", v, 8'h00);
   endtask

   task automatic t_saturate();
      do_reset();
      for (int i = 0; i < 70; i++) vread(14'h2000 + 14'(i * 2));
      chk("R10 slot counter saturates", slot_cnt, 63);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_repeat();
      t_fourth();
      t_irq_count();
      t_enable();
      t_idle();
      t_vector();
      t_saturate();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule